// File: doc/BRIEF.md
# Hierarchical Cache Power Requirement Resolver

This block decides which cache slices must be powered, given which shader cores are powered now and which are wanted. A slice serves a contiguous run of consumer indices. The run starts at the slice's own index and ends just below the next present slice above it. Each present slice is turned on when any consumer in its run needs power. The result is chained through three levels. Shader cores decide the L2 slices. The final L2 mask decides the L3 slices. Any powered L2 slice also turns on slice 0 and every tiler.

A power controller drives the present masks, the ready and wanted shader masks, and a count of L2 users. It reads the three demand masks one clock later and feeds them to the per-domain transition logic, which is not part of this block. All masks share one index space of `SLICE_W` bits. The tiler mask has `TILER_W` bits.

Top module: `cpr_power_resolver`

## Requirements
- R1: While `rst` is high, and on the first clock after it, all three demand outputs are zero.
- R2: A present slice k is set in a resolved mask exactly when some consumer bit j is set, where k <= j and no present slice lies in the range k+1..j.
- R3: An all-zero present mask gives an all-zero resolved mask. A consumer bit below the lowest present slice never enables any slice.
- R4: The L2 consumer mask is the bitwise OR of the ready shader mask and the wanted shader mask.
- R5: A non-zero L2 user count adds the whole L2 present mask to the L2 consumers, so every present L2 slice is demanded.
- R6: When the resolved L2 mask is non-zero, bit 0 of `l2_need` is forced to 1, whether or not slice 0 is present. When it is zero, `l2_need` is zero.
- R7: `tiler_need` equals `tiler_present` when `l2_need` is non-zero, and is zero otherwise.
- R8: `l3_need` is the R2 resolution of `l3_present`, using the final `l2_need` (after bit 0 is forced) as its consumer mask.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising edge of `clk`, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l2_present | input | SLICE_W | L2 slices that exist |
| l3_present | input | SLICE_W | L3 slices that exist |
| tiler_present | input | TILER_W | Tilers that exist |
| shader_ready | input | SLICE_W | Shader cores currently powered |
| shader_want | input | SLICE_W | Shader cores requested on |
| l2_users | input | USER_W | Number of clients holding the L2 on |
| l2_need | output | SLICE_W | L2 slices that must be on |
| l3_need | output | SLICE_W | L3 slices that must be on |
| tiler_need | output | TILER_W | Tilers that must be on |

## Verification
A wrong ownership range shows up in the next cycle. Either a slice that should be on is missing from `l2_need`, or a slice below the owner is lit. A wrong L2 result then also shows in `l3_need` and `tiler_need` in that same cycle, because the levels are chained before the output register. A slip in the register stage shows as outputs that match the inputs of the wrong cycle. The bench drives new masks every clock, so such a slip appears at the first change of the inputs.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

    localparam int SLICE_W = 16;
    localparam int TILER_W = 4;
    localparam int USER_W  = 6;

    typedef logic [SLICE_W-1:0] slice_mask_t;
    typedef logic [TILER_W-1:0] tiler_mask_t;
    typedef logic [USER_W-1:0]  user_cnt_t;

    // Demand bundle carried from the resolve logic to the output register
    typedef struct packed {
        slice_mask_t l2;
        slice_mask_t l3;
        tiler_mask_t tiler;
    } cpr_demand_t;

    // Slice 0 of the L2 anchors the job path: lit whenever any slice is lit
    function automatic slice_mask_t anchor_slice0(slice_mask_t m);
        slice_mask_t r;
        r = m;
        if (m != '0) begin
            r[0] = 1'b1;
        end
        return r;
    endfunction

    // Consumers for the L2 level: powered cores, wanted cores, held slices
    function automatic slice_mask_t l2_consumers(slice_mask_t ready,
                                                 slice_mask_t want,
                                                 slice_mask_t l2_pres,
                                                 user_cnt_t   users);
        slice_mask_t r;
        r = ready | want;
        if (users != '0) begin
            r = r | l2_pres;
        end
        return r;
    endfunction

endpackage

// File: rtl/cpr_slice_resolver.sv
module cpr_slice_resolver
    import cpr_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] present,
    input  logic [W-1:0] consumer,
    output logic [W-1:0] claimed
);

    // For each slice i, the window runs from i upward until the next
    // present slice; the slice is claimed if a consumer lies in it.
    for (genvar i = 0; i < W; i++) begin : g_slice
        logic [W-1:0] window;

        always_comb begin
            logic open;
            open   = 1'b1;
            window = '0;
            for (int j = i; j < W; j++) begin
                if (j > i && present[j]) begin
                    open = 1'b0;
                end
                window[j] = open;
            end
        end

        assign claimed[i] = present[i] & (|(window & consumer));
    end

endmodule

// File: rtl/cpr_l2_stage.sv
module cpr_l2_stage
    import cpr_pkg::*;
(
    input  slice_mask_t l2_present,
    input  tiler_mask_t tiler_present,
    input  slice_mask_t shader_ready,
    input  slice_mask_t shader_want,
    input  user_cnt_t   l2_users,
    output slice_mask_t l2_demand,
    output tiler_mask_t tiler_demand
);

    slice_mask_t consumers;
    slice_mask_t raw_claim;

    assign consumers = l2_consumers(shader_ready, shader_want, l2_present, l2_users);

    cpr_slice_resolver #(.W(SLICE_W)) u_l2_res (
        .present  (l2_present),
        .consumer (consumers),
        .claimed  (raw_claim)
    );

    always_comb begin
        l2_demand    = anchor_slice0(raw_claim);
        tiler_demand = (raw_claim != '0) ? tiler_present : '0;
    end

endmodule

// File: rtl/cpr_l3_stage.sv
module cpr_l3_stage
    import cpr_pkg::*;
(
    input  slice_mask_t l3_present,
    input  slice_mask_t l2_demand,
    output slice_mask_t l3_demand
);

    cpr_slice_resolver #(.W(SLICE_W)) u_l3_res (
        .present  (l3_present),
        .consumer (l2_demand),
        .claimed  (l3_demand)
    );

endmodule

// File: rtl/cpr_power_resolver.sv
module cpr_power_resolver
    import cpr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SLICE_W-1:0]  l2_present,
    input  logic [SLICE_W-1:0]  l3_present,
    input  logic [TILER_W-1:0]  tiler_present,
    input  logic [SLICE_W-1:0]  shader_ready,
    input  logic [SLICE_W-1:0]  shader_want,
    input  logic [USER_W-1:0]   l2_users,
    output logic [SLICE_W-1:0]  l2_need,
    output logic [SLICE_W-1:0]  l3_need,
    output logic [TILER_W-1:0]  tiler_need
);

    cpr_demand_t next_d;
    cpr_demand_t cur_d;

    cpr_l2_stage u_l2 (
        .l2_present    (l2_present),
        .tiler_present (tiler_present),
        .shader_ready  (shader_ready),
        .shader_want   (shader_want),
        .l2_users      (l2_users),
        .l2_demand     (next_d.l2),
        .tiler_demand  (next_d.tiler)
    );

    cpr_l3_stage u_l3 (
        .l3_present (l3_present),
        .l2_demand  (next_d.l2),
        .l3_demand  (next_d.l3)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_d <= '0;
        end else begin
            cur_d <= next_d;
        end
    end

    assign l2_need    = cur_d.l2;
    assign l3_need    = cur_d.l3;
    assign tiler_need = cur_d.tiler;

endmodule

// File: rtl/cpr_power_resolver_chk.sv
module cpr_power_resolver_chk
    import cpr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [SLICE_W-1:0]  l2_present,
    input logic [SLICE_W-1:0]  l3_present,
    input logic [TILER_W-1:0]  tiler_present,
    input logic [USER_W-1:0]   l2_users,
    input logic [SLICE_W-1:0]  l2_need,
    input logic [SLICE_W-1:0]  l3_need,
    input logic [TILER_W-1:0]  tiler_need
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (l2_need == '0 && l3_need == '0 && tiler_need == '0));

    // R6
    anchor_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (l2_need != '0) |-> l2_need[0]);

    // R7
    tiler_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tiler_need == ((l2_need != '0) ? $past(tiler_present) : '0)));

    // R8
    l3_within_present_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((l3_need & ~$past(l3_present)) == '0));

    // R2
    l2_within_present_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((l2_need & ~($past(l2_present) | 1)) == '0));

    // R5
    users_hold_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(l2_users) != '0 && $past(l2_present) != '0)
            |-> (l2_need == ($past(l2_present) | 1)));

    // R8
    l3_idle_when_l2_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (l2_need == '0) |-> (l3_need == '0));

endmodule

bind cpr_power_resolver cpr_power_resolver_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .l2_present    (l2_present),
    .l3_present    (l3_present),
    .tiler_present (tiler_present),
    .l2_users      (l2_users),
    .l2_need       (l2_need),
    .l3_need       (l3_need),
    .tiler_need    (tiler_need)
);

// File: tb/test_cpr_power_resolver.sv
`timescale 1ns/1ps
module test_cpr_power_resolver;
    import cpr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SLICE_W-1:0] l2_present = '0, l3_present = '0, shader_ready = '0, shader_want = '0;
    logic [TILER_W-1:0] tiler_present = '0;
    logic [USER_W-1:0]  l2_users = '0;
    logic [SLICE_W-1:0] l2_need, l3_need;
    logic [TILER_W-1:0] tiler_need;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cpr_power_resolver i_cpr_power_resolver (
        .clk(clk), .rst(rst),
        .l2_present(l2_present), .l3_present(l3_present), .tiler_present(tiler_present),
        .shader_ready(shader_ready), .shader_want(shader_want), .l2_users(l2_users),
        .l2_need(l2_need), .l3_need(l3_need), .tiler_need(tiler_need)
    );

    // Reference: every consumer bit j is owned by the highest present slice at or below j
    function automatic logic [SLICE_W-1:0] owner_map(logic [SLICE_W-1:0] pres,
                                                     logic [SLICE_W-1:0] cons);
        logic [SLICE_W-1:0] res = '0;
        for (int j = 0; j < SLICE_W; j++) begin
            if (cons[j]) begin
                int owner = -1;
                for (int k = 0; k <= j; k++) if (pres[k]) owner = k;
                if (owner >= 0) res[owner] = 1'b1;
            end
        end
        return res;
    endfunction

    logic [SLICE_W-1:0] exp_l2, exp_l3;
    logic [TILER_W-1:0] exp_t;

    task automatic compute_expected();
        logic [SLICE_W-1:0] cons;
        cons = shader_ready | shader_want;                 // R4
        if (l2_users != 0) cons = cons | l2_present;       // R5
        exp_l2 = owner_map(l2_present, cons);              // R2, R3
        exp_t  = (exp_l2 != 0) ? tiler_present : '0;       // R7
        if (exp_l2 != 0) exp_l2[0] = 1'b1;                 // R6
        exp_l3 = owner_map(l3_present, exp_l2);            // R8
    endtask

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, sample one edge later (R9)
    task automatic step(string tag, logic [SLICE_W-1:0] l2p, logic [SLICE_W-1:0] l3p,
                        logic [TILER_W-1:0] tp, logic [SLICE_W-1:0] rdy,
                        logic [SLICE_W-1:0] wnt, logic [USER_W-1:0] us);
        @(negedge clk);
        l2_present = l2p; l3_present = l3p; tiler_present = tp;
        shader_ready = rdy; shader_want = wnt; l2_users = us;
        compute_expected();
        @(posedge clk);
        #1;
        check_val({tag, " l2"}, 32'(l2_need), 32'(exp_l2));
        check_val({tag, " l3"}, 32'(l3_need), 32'(exp_l3));
        check_val({tag, " tiler"}, 32'(tiler_need), 32'(exp_t));
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with demanding inputs
        l2_present = 16'h0F0F; shader_want = 16'hFFFF; tiler_present = 4'hF; l3_present = 16'h0101;
        repeat (3) @(posedge clk);
        #1;
        check_val("R1 l2", 32'(l2_need), 0);
        check_val("R1 l3", 32'(l3_need), 0);
        check_val("R1 tiler", 32'(tiler_need), 0);
        @(negedge clk); rst = 1'b0;

        // R3: empty present mask
        step("R3 empty", 16'h0000, 16'h0000, 4'h3, 16'hFFFF, 16'hFFFF, 6'd0);
        // R3: consumers below lowest present slice
        step("R3 below", 16'h0010, 16'h0010, 4'h3, 16'h000F, 16'h0000, 6'd0);
        // R2: ownership ranges, consumer at 9 belongs to slice 8
        step("R2 range", 16'h0111, 16'h0001, 4'h1, 16'h0000, 16'h0200, 6'd0);
        // R4: ready alone lights slice
        step("R4 ready", 16'h1111, 16'h0101, 4'h7, 16'h2000, 16'h0000, 6'd0);
        // R5: users hold all slices
        step("R5 users", 16'h8421, 16'h0001, 4'h2, 16'h0000, 16'h0000, 6'd3);
        // R6: bit 0 forced though slice 0 absent
        step("R6 anchor", 16'h0300, 16'h0100, 4'h1, 16'h0000, 16'h0200, 6'd0);
        // R7: no L2 demand, tilers off
        step("R7 idle", 16'hFFFF, 16'hFFFF, 4'hF, 16'h0000, 16'h0000, 6'd0);
        // R8: L3 chained from forced L2 bit 0
        step("R8 chain", 16'h00C0, 16'h0041, 4'h1, 16'h0080, 16'h0000, 6'd0);
        // R9: back-to-back changes each cycle
        for (int n = 0; n < 400; n++) begin
            step("R9 random", 16'($urandom), 16'($urandom) & 16'($urandom), 4'($urandom),
                 16'($urandom) & 16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom),
                 ($urandom % 4 == 0) ? 6'd1 : 6'd0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule